// File: doc/BRIEF.md
# Programmable Bus Byte-Order Swapper

This block stands between a little-endian host data path and a 32-bit big-endian system bus. For each transfer it decides whether the byte lanes must be reversed. It then applies that reordering to the outgoing write data and to the read data that comes back from the bus.

The order is taken from one of two sources. A paged access uses one control bit of a small writable modifier register. A direct-mapped access takes its order from the host address window it falls in. One window gives big-endian order and a second window, an alias of the same 24-bit bus space, gives little-endian order. Single-byte transfers are never reordered. A direct-mapped access that lands outside both windows is flagged and passed through unchanged.

The ordering decision is captured when an access is presented. The write data, window code and flag appear one cycle later and hold until the next access. Read data returning from the bus is reordered combinationally under the same captured decision, so every access sees one symmetric swap.

Top module: `endian_lane_bridge`

## Requirements
- R1: After synchronous reset the order bit is 0 (little-endian), `bus_wdata` is 0, `win_code` is 0, `no_window` is 0, and `host_rdata` equals `bus_rdata`.
- R2: A write with `cfg_wr_en` high and `cfg_addr` equal to 16'h8151 loads `cfg_wdata[5]` as the order bit (1 = big-endian). A write to any other offset leaves the order bit unchanged.
- R3: An access with `acc_paged` high uses the order bit held before that clock edge, and it reports `win_code` 1.
- R4: A direct-mapped access with `acc_addr[31:24]` equal to 8'hE0 uses big-endian order and reports `win_code` 2.
- R5: A direct-mapped access with `acc_addr[31:24]` equal to 8'h20 uses little-endian order and reports `win_code` 3. In little-endian order, data passes through unchanged in both directions.
- R6: A direct-mapped access in neither window sets `no_window` to 1, reports `win_code` 0 and passes its data through unchanged. Any access that hits a window clears `no_window`.
- R7: A byte transfer (`acc_size` 0) is never reordered, whatever the order.
- R8: A big-endian double-word transfer (`acc_size` 2) reverses all four byte lanes, so that lane k receives lane 3-k.
- R9: A big-endian word transfer (`acc_size` 1) exchanges the two bytes of the half-word chosen by `acc_addr[1]` (0 selects lanes 0/1, 1 selects lanes 2/3). The other half-word passes through unchanged.
- R10: `host_rdata` is `bus_rdata` reordered under the order, size and half-word captured by the most recent access. It follows `bus_rdata` in the same cycle.
- R11: `bus_wdata`, `win_code` and `no_window` update on the clock edge where `acc_valid` is high and hold while `acc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Modifier register write strobe |
| cfg_addr | input | 16 | Register offset of the write |
| cfg_wdata | input | 8 | Register write data; bit 5 is the order bit |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_paged | input | 1 | 1 = paged access, 0 = direct-mapped |
| acc_addr | input | 32 | Host address of the access |
| acc_size | input | 2 | 0 byte, 1 word, 2 double-word |
| host_wdata | input | 32 | Host write data |
| bus_rdata | input | 32 | Read data returning from the bus |
| bus_wdata | output | 32 | Reordered write data toward the bus |
| host_rdata | output | 32 | Reordered read data toward the host |
| win_code | output | 2 | 0 none, 1 paged, 2 big window, 3 little window |
| no_window | output | 1 | The last direct-mapped access hit no window |

## Verification
The write-side results (`bus_wdata`, `win_code`, `no_window`) are due on the first rising edge after an access is presented. `host_rdata` has no latency with respect to `bus_rdata`, but it depends on the state captured at that same edge. The bench drives inputs 2 ns after each rising edge. A behavioural model updates on the edge, and all outputs are compared against it 2 ns after the next edge, so every output is checked in the cycle it becomes valid. Order-bit writes that land on the same edge as a paged access are modelled as taking effect only on later accesses.

// File: rtl/endian_pkg.sv
package endian_pkg;

    localparam int BUS_W      = 32;
    localparam int LANE_N     = BUS_W / 8;
    localparam int HALF_W     = (LANE_N > 2) ? $clog2(LANE_N / 2) : 1;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_PAGED  = 2'd1,
        WIN_BIG    = 2'd2,
        WIN_LITTLE = 2'd3
    } win_e;

    typedef struct packed {
        logic              big;
        xfer_size_e        size;
        logic [HALF_W-1:0] half;
    } swap_ctl_t;

    function automatic logic [BUS_W-1:0] lane_reverse(input logic [BUS_W-1:0] d);
        logic [BUS_W-1:0] r;
        for (int k = 0; k < LANE_N; k++) begin
            r[k*8 +: 8] = d[(LANE_N-1-k)*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/order_ctl.sv
module order_ctl #(
    parameter int              OFFS_W    = 16,
    parameter logic [15:0]     OFFSET    = 16'h8151,
    parameter int              DW        = 8,
    parameter int              ORDER_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              order_big
);

    logic hit;
    assign hit = wr_en && (wr_addr == OFFSET[OFFS_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            order_big <= 1'b0;
        end else if (hit) begin
            order_big <= wr_data[ORDER_BIT];
        end
    end

    // R2
    foreign_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != OFFSET[OFFS_W-1:0]) |=> $stable(order_big));

    // R2
    load_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFFSET[OFFS_W-1:0]) |=> (order_big == $past(wr_data[ORDER_BIT])));

endmodule

// File: rtl/window_decode.sv
module window_decode
    import endian_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          WIN_LSB = 24,
    parameter logic [7:0]  BIG_TAG = 8'hE0,
    parameter logic [7:0]  LIT_TAG = 8'h20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              paged,
    input  logic              order_big,
    output win_e              win,
    output logic              big,
    output logic              no_win
);

    localparam int TAG_W = ADDR_W - WIN_LSB;

    logic [TAG_W-1:0] tag;
    assign tag = addr[ADDR_W-1:WIN_LSB];

    always_comb begin
        win    = WIN_NONE;
        big    = 1'b0;
        no_win = 1'b0;
        if (paged) begin
            win = WIN_PAGED;
            big = order_big;
        end else if (tag == BIG_TAG[TAG_W-1:0]) begin
            win = WIN_BIG;
            big = 1'b1;
        end else if (tag == LIT_TAG[TAG_W-1:0]) begin
            win = WIN_LITTLE;
        end else begin
            no_win = 1'b1;
        end
    end

endmodule

// File: rtl/lane_reorder.sv
module lane_reorder
    import endian_pkg::*;
#(
    parameter int LANES = LANE_N
) (
    input  logic [LANES*8-1:0] din,
    input  swap_ctl_t          ctl,
    output logic [LANES*8-1:0] dout
);

    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int PAIR = i / 2;
        logic [IDX_W-1:0] src;
        always_comb begin
            src = IDX_W'(i);
            if (ctl.big) begin
                if (ctl.size == SZ_DWORD) begin
                    src = IDX_W'(LANES - 1 - i);
                end else if (ctl.size == SZ_WORD && ctl.half == HALF_W'(PAIR)) begin
                    src = IDX_W'(i ^ 1);
                end
            end
        end
        assign dout[i*8 +: 8] = din[src*8 +: 8];
    end

endmodule

// File: rtl/endian_lane_bridge.sv
module endian_lane_bridge
    import endian_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          WIN_LSB   = 24,
    parameter logic [7:0]  BIG_TAG   = 8'hE0,
    parameter logic [7:0]  LIT_TAG   = 8'h20,
    parameter logic [15:0] MOD_OFFS  = 16'h8151,
    parameter int          ORDER_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [15:0]       cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_paged,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [BUS_W-1:0]  host_wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  host_rdata,
    output logic [1:0]        win_code,
    output logic              no_window
);

    logic             order_big;
    win_e             win_d;
    logic             big_d;
    logic             nowin_d;
    swap_ctl_t        ctl_d;
    swap_ctl_t        ctl_q;
    logic [BUS_W-1:0] wr_swapped;
    win_e             win_q;

    order_ctl #(
        .OFFS_W   (16),
        .OFFSET   (MOD_OFFS),
        .DW       (8),
        .ORDER_BIT(ORDER_BIT)
    ) i_order (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .order_big(order_big)
    );

    window_decode #(
        .ADDR_W (ADDR_W),
        .WIN_LSB(WIN_LSB),
        .BIG_TAG(BIG_TAG),
        .LIT_TAG(LIT_TAG)
    ) i_win (
        .addr     (acc_addr),
        .paged    (acc_paged),
        .order_big(order_big),
        .win      (win_d),
        .big      (big_d),
        .no_win   (nowin_d)
    );

    always_comb begin
        ctl_d.big  = big_d;
        ctl_d.size = xfer_size_e'(acc_size);
        ctl_d.half = acc_addr[1 +: HALF_W];
    end

    lane_reorder #(.LANES(LANE_N)) i_wr_swap (
        .din (host_wdata),
        .ctl (ctl_d),
        .dout(wr_swapped)
    );

    lane_reorder #(.LANES(LANE_N)) i_rd_swap (
        .din (bus_rdata),
        .ctl (ctl_q),
        .dout(host_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            bus_wdata <= '0;
            win_q     <= WIN_NONE;
            no_window <= 1'b0;
        end else if (acc_valid) begin
            ctl_q     <= ctl_d;
            bus_wdata <= wr_swapped;
            win_q     <= win_d;
            no_window <= nowin_d;
        end
    end

    assign win_code = win_q;

    // R7
    byte_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_size == 2'd0) |=> (bus_wdata == $past(host_wdata)));

    // R8
    dword_reverse_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_paged && acc_addr[31:24] == BIG_TAG && acc_size == 2'd2)
        |=> (bus_wdata == lane_reverse($past(host_wdata))));

    // R6
    no_window_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_paged && acc_addr[31:24] != BIG_TAG && acc_addr[31:24] != LIT_TAG)
        |=> (no_window && win_code == 2'd0 && bus_wdata == $past(host_wdata)));

    // R5
    little_read_chk: assert property (@(posedge clk) disable iff (rst)
        (win_code == 2'd3) |-> (host_rdata == bus_rdata));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> ($stable(bus_wdata) && $stable(win_code) && $stable(no_window)));

endmodule

// File: tb/test_endian_lane_bridge.sv
`timescale 1ns/1ps
module test_endian_lane_bridge;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en;
    logic [15:0] cfg_addr;
    logic [7:0]  cfg_wdata;
    logic        acc_valid;
    logic        acc_paged;
    logic [31:0] acc_addr;
    logic [1:0]  acc_size;
    logic [31:0] host_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] bus_wdata;
    logic [31:0] host_rdata;
    logic [1:0]  win_code;
    logic        no_window;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit          m_order;
    bit          m_big;
    int          m_size;
    int          m_half;
    int          m_win;
    bit          m_nowin;
    logic [31:0] m_wdata;

    always #2.5 clk = ~clk;

    endian_lane_bridge i_endian_lane_bridge (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .acc_valid (acc_valid),
        .acc_paged (acc_paged),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .host_wdata(host_wdata),
        .bus_rdata (bus_rdata),
        .bus_wdata (bus_wdata),
        .host_rdata(host_rdata),
        .win_code  (win_code),
        .no_window (no_window)
    );

    function automatic logic [31:0] ref_swap(input logic [31:0] d, input bit big,
                                             input int sz, input int half);
        logic [7:0] b [4];
        logic [7:0] o [4];
        for (int k = 0; k < 4; k++) begin
            b[k] = d[8*k +: 8];
            o[k] = b[k];
        end
        if (big && sz == 2) begin
            for (int k = 0; k < 4; k++) o[k] = b[3-k];
        end else if (big && sz == 1) begin
            o[2*half]   = b[2*half+1];
            o[2*half+1] = b[2*half];
        end
        return {o[3], o[2], o[1], o[0]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_order <= 0; m_big <= 0; m_size <= 0; m_half <= 0;
            m_win <= 0; m_nowin <= 0; m_wdata <= '0;
        end else begin
            if (acc_valid) begin
                bit b; int w; bit nw;
                b = 0; w = 0; nw = 0;
                if (acc_paged) begin
                    b = m_order; w = 1;
                end else if (acc_addr[31:24] == 8'hE0) begin
                    b = 1; w = 2;
                end else if (acc_addr[31:24] == 8'h20) begin
                    b = 0; w = 3;
                end else begin
                    nw = 1;
                end
                m_big   <= b;
                m_size  <= int'(acc_size);
                m_half  <= int'(acc_addr[1]);
                m_win   <= w;
                m_nowin <= nw;
                m_wdata <= ref_swap(host_wdata, b, int'(acc_size), int'(acc_addr[1]));
            end
            if (cfg_wr_en && cfg_addr == 16'h8151) m_order <= cfg_wdata[5];
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        check("bus_wdata", bus_wdata, m_wdata);
        check("win_code", {30'd0, win_code}, m_win);
        check("no_window", {31'd0, no_window}, {31'd0, m_nowin});
        check("host_rdata", host_rdata, ref_swap(bus_rdata, m_big, m_size, m_half));
    endtask

    task automatic idle();
        acc_valid = 0; cfg_wr_en = 0;
    endtask

    task automatic access(input bit paged, input logic [31:0] a, input int sz,
                          input logic [31:0] d);
        acc_valid = 1; acc_paged = paged; acc_addr = a;
        acc_size = 2'(sz); host_wdata = d;
        tick();
        acc_valid = 0;
    endtask

    task automatic cfg(input logic [15:0] a, input logic [7:0] d);
        cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_wr_en = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; idle(); acc_paged = 0; acc_addr = 0; acc_size = 0;
        host_wdata = 0; bus_rdata = 32'h1234_5678; cfg_addr = 0; cfg_wdata = 0;
        tick(); tick();
        rst = 0;
        cur_req = "R1";
        tick();
        check("reset bus_wdata", bus_wdata, 32'h0);
        check("reset host_rdata passthrough", host_rdata, 32'h1234_5678);

        cur_req = "R5";
        access(0, 32'h2012_3400, 2, 32'h7654_3210);
        check("little window data", bus_wdata, 32'h7654_3210);
        bus_rdata = 32'hAABB_CCDD; tick();

        cur_req = "R8";
        access(0, 32'hE000_0010, 2, 32'h7654_3210);
        check("dword reversed", bus_wdata, 32'h1032_5476);
        cur_req = "R4";
        check("big window code", {30'd0, win_code}, 32'd2);
        cur_req = "R10";
        bus_rdata = 32'hAABB_CCDD; tick();
        check("read reversed", host_rdata, 32'hDDCC_BBAA);

        cur_req = "R9";
        access(0, 32'hE000_0000, 1, 32'h1122_3344);
        check("word low half", bus_wdata, 32'h1122_4433);
        access(0, 32'hE000_0002, 1, 32'h1122_3344);
        check("word high half", bus_wdata, 32'h2211_3344);

        cur_req = "R7";
        access(0, 32'hE000_0003, 0, 32'hCAFE_F00D);
        check("byte untouched", bus_wdata, 32'hCAFE_F00D);

        cur_req = "R2";
        cfg(16'h8150, 8'h20);
        access(1, 32'h0000_0100, 2, 32'h0102_0304);
        check("foreign offset ignored", bus_wdata, 32'h0102_0304);
        cfg(16'h8151, 8'h20);
        cur_req = "R3";
        access(1, 32'h0000_0100, 2, 32'h0102_0304);
        check("paged big", bus_wdata, 32'h0403_0201);
        check("paged code", {30'd0, win_code}, 32'd1);
        // order change on the same edge as a paged access: old bit used
        cfg_wr_en = 1; cfg_addr = 16'h8151; cfg_wdata = 8'h00;
        access(1, 32'h0000_0104, 2, 32'hA1B2_C3D4);
        cfg_wr_en = 0;
        check("same-edge old order", bus_wdata, 32'hD4C3_B2A1);
        access(1, 32'h0000_0104, 2, 32'hA1B2_C3D4);
        check("paged little", bus_wdata, 32'hA1B2_C3D4);

        cur_req = "R6";
        access(0, 32'h3000_0000, 2, 32'h5566_7788);
        check("no window flag", {31'd0, no_window}, 32'd1);
        check("no window data", bus_wdata, 32'h5566_7788);
        access(0, 32'h20FF_FFFC, 2, 32'h0);
        check("flag cleared", {31'd0, no_window}, 32'd0);

        cur_req = "R11";
        access(0, 32'hE000_0000, 2, 32'h0A0B_0C0D);
        host_wdata = 32'hFFFF_FFFF;
        tick(); tick();
        check("held write data", bus_wdata, 32'h0D0C_0B0A);

        cur_req = "R10";
        for (int n = 0; n < 60; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[4]) cfg(16'h8151, {2'b00, r[5], 5'b0});
            bus_rdata = $urandom;
            access(r[0], {(r[2] ? 8'hE0 : (r[3] ? 8'h20 : 8'h44)), r[31:10], r[1:0]},
                   int'(r[7:6] % 3), $urandom);
            bus_rdata = $urandom;
            tick();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule